// File: doc/BRIEF.md
# Pipeline Operand Forwarding Select Unit

This block produces the multiplexer select codes that steer fresh results around the register file in a five-stage in-order integer pipeline. Branches and register jumps are resolved in the decode stage. The block compares source register numbers against the destination numbers of older instructions still in flight. For each operand it then says where the newest copy of that register lives.

The execute stage has two ALU operands. Each one picks from three sources: the register file value, the ALU result waiting in the execute/memory register, or the result waiting in the memory/writeback register. The same muxes also feed the link-address path of jump-and-link instructions, so the selects depend only on register numbers and not on the opcode. The decode stage has two comparison and jump-target operands. These pick only between the register file value and the execute/memory ALU result. A writeback value needs no decode bypass, because the register file writes before it reads.

A load sitting in the memory stage holds an address rather than data in its ALU result. It is therefore never forwarded, and the stall logic elsewhere handles that case. The block is purely combinational.

Top module: `fwd_unit`

## Requirements
- R1: When no valid older writer names an execute operand's source register, that operand's select is 2'b00 (register file).
- R2: When the execute/memory instruction writes (enable high, not a load) a nonzero destination equal to an execute operand's source, that operand's select is 2'b01.
- R3: When only the memory/writeback instruction writes a nonzero destination equal to an execute operand's source, that operand's select is 2'b10.
- R4: When both older stages write the same nonzero register that an execute operand reads, the execute/memory copy wins and the select is 2'b01.
- R5: A destination of register 0 never causes forwarding on any select, for either stage.
- R6: A stage whose write-enable is low (a bubble) never causes forwarding, whatever its destination number.
- R7: When the execute/memory instruction is a load whose destination matches, both the execute and the decode select for that operand are 2'b00. This holds even if the memory/writeback stage also matches.
- R8: A decode select is 2'b01 exactly when the execute/memory instruction validly matches that operand's source and is not a load; otherwise it is 2'b00. A memory/writeback match alone never changes it.
- R9: No execute select ever takes the value 2'b11, and no decode select ever takes a value above 2'b01.
- R10: Each operand's select depends only on its own source register number, so the two operands of one stage may receive different selects in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_W | First source register of the decode-stage instruction |
| id_src_b | input | REG_W | Second source register of the decode-stage instruction |
| ex_src_a | input | REG_W | First source register of the execute-stage instruction |
| ex_src_b | input | REG_W | Second source register of the execute-stage instruction |
| exm_dst | input | REG_W | Destination register of the execute/memory instruction |
| exm_wr | input | 1 | Execute/memory instruction writes the register file |
| exm_ld | input | 1 | Execute/memory instruction is a load |
| mwb_dst | input | REG_W | Destination register of the memory/writeback instruction |
| mwb_wr | input | 1 | Memory/writeback instruction writes the register file |
| ex_sel_a | output | 2 | Execute operand A select (00 file, 01 exe/mem, 10 mem/wb) |
| ex_sel_b | output | 2 | Execute operand B select |
| id_sel_a | output | 2 | Decode operand A select (00 file, 01 exe/mem) |
| id_sel_b | output | 2 | Decode operand B select |

## Verification
Every select is a combinational function of the current inputs, so each result is due in the same cycle its stimulus is applied, with no register in the path. The bench applies each input pattern just after a rising edge and reads the four selects at the following falling edge. That gives the logic half a period to settle, and each sample is taken before the next pattern replaces it. With 3-bit register numbers, the sweep covers every source, every pair of destinations and every combination of the three flags. The two operands of each stage get different sources, so that independence is also exercised.

// File: rtl/fwd_pkg.sv
// Shared encodings for the operand forwarding unit.
// Assumes 2-bit select buses on every operand mux.
package fwd_pkg;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_EXM = 2'b01,
        SEL_MWB = 2'b10
    } fwd_sel_e;

endpackage

// File: rtl/fwd_hit.sv
// Detects that an older in-flight instruction will write the register an
// operand reads. Assumes register 0 is hardwired to zero and that a bubble
// arrives with its write-enable cleared.
module fwd_hit #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    input  logic             wr,
    output logic             hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    // Match only a real, nonzero destination of a writing instruction.
    always_comb begin
        hit = wr && (dst != ZERO_REG) && (dst == src);
    end
endmodule

// File: rtl/fwd_ex_pick.sv
// Priority chooser for one execute-stage operand. The execute/memory stage
// is newest and wins. A matching load there suppresses forwarding entirely,
// because its ALU result is an address; stall logic is assumed to hold it.
module fwd_ex_pick
    import fwd_pkg::*;
(
    input  logic     hit_exm,
    input  logic     exm_ld,
    input  logic     hit_mwb,
    output fwd_sel_e sel
);
    // Newest valid source first, load match falls back to the file.
    always_comb begin
        if (hit_exm) begin
            sel = exm_ld ? SEL_RF : SEL_EXM;
        end else if (hit_mwb) begin
            sel = SEL_MWB;
        end else begin
            sel = SEL_RF;
        end
    end
endmodule

// File: rtl/fwd_id_pick.sv
// Chooser for one decode-stage operand. Only the execute/memory ALU result is
// a bypass source; writeback data reaches decode through the write-first file.
module fwd_id_pick
    import fwd_pkg::*;
(
    input  logic     hit_exm,
    input  logic     exm_ld,
    output fwd_sel_e sel
);
    // Bypass a non-load execute/memory result, else read the file.
    always_comb begin
        sel = (hit_exm && !exm_ld) ? SEL_EXM : SEL_RF;
    end
endmodule

// File: rtl/fwd_unit.sv
// Top of the forwarding select logic. Instantiates one match pair and one
// chooser per operand: two execute operands, two decode operands. The logic is
// purely combinational; the selects serve ALU operands, link-address muxes and
// decode compare/jump-target muxes alike.
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    input  logic [REG_W-1:0] ex_src_a,
    input  logic [REG_W-1:0] ex_src_b,
    input  logic [REG_W-1:0] exm_dst,
    input  logic             exm_wr,
    input  logic             exm_ld,
    input  logic [REG_W-1:0] mwb_dst,
    input  logic             mwb_wr,
    output logic [1:0]       ex_sel_a,
    output logic [1:0]       ex_sel_b,
    output logic [1:0]       id_sel_a,
    output logic [1:0]       id_sel_b
);
    localparam int N_OPS = 2;

    logic [REG_W-1:0] ex_src [N_OPS];
    logic [REG_W-1:0] id_src [N_OPS];
    fwd_sel_e         ex_sel [N_OPS];
    fwd_sel_e         id_sel [N_OPS];

    // Gather operand sources into arrays for the generate loop.
    always_comb begin
        ex_src[0] = ex_src_a;
        ex_src[1] = ex_src_b;
        id_src[0] = id_src_a;
        id_src[1] = id_src_b;
    end

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        logic ex_hit_exm, ex_hit_mwb, id_hit_exm;

        fwd_hit #(.REG_W(REG_W)) u_ex_exm (
            .src(ex_src[g]), .dst(exm_dst), .wr(exm_wr), .hit(ex_hit_exm));
        fwd_hit #(.REG_W(REG_W)) u_ex_mwb (
            .src(ex_src[g]), .dst(mwb_dst), .wr(mwb_wr), .hit(ex_hit_mwb));
        fwd_hit #(.REG_W(REG_W)) u_id_exm (
            .src(id_src[g]), .dst(exm_dst), .wr(exm_wr), .hit(id_hit_exm));

        fwd_ex_pick u_ex_pick (
            .hit_exm(ex_hit_exm), .exm_ld(exm_ld), .hit_mwb(ex_hit_mwb),
            .sel(ex_sel[g]));
        fwd_id_pick u_id_pick (
            .hit_exm(id_hit_exm), .exm_ld(exm_ld), .sel(id_sel[g]));
    end

    // Drive the flat output ports from the per-operand selects.
    always_comb begin
        ex_sel_a = ex_sel[0];
        ex_sel_b = ex_sel[1];
        id_sel_a = id_sel[0];
        id_sel_b = id_sel[1];
    end
endmodule

// File: rtl/fwd_unit_chk.sv
// Port-level checker for fwd_unit, attached by bind. The block has no clock,
// so every rule is an immediate assertion re-evaluated on any input change.
module fwd_unit_chk #(
    parameter int REG_W = 5
) (
    input logic [REG_W-1:0] id_src_a,
    input logic [REG_W-1:0] id_src_b,
    input logic [REG_W-1:0] ex_src_a,
    input logic [REG_W-1:0] ex_src_b,
    input logic [REG_W-1:0] exm_dst,
    input logic             exm_wr,
    input logic             exm_ld,
    input logic [REG_W-1:0] mwb_dst,
    input logic             mwb_wr,
    input logic [1:0]       ex_sel_a,
    input logic [1:0]       ex_sel_b,
    input logic [1:0]       id_sel_a,
    input logic [1:0]       id_sel_b
);
    // Check output legality and the stage-to-stage rules on each change.
    always_comb begin
        AST_EX_CODE_LEGAL: assert (ex_sel_a != 2'b11 && ex_sel_b != 2'b11); // R9
        AST_ID_CODE_LEGAL: assert (id_sel_a <= 2'b01 && id_sel_b <= 2'b01); // R9
        AST_ZERO_DST_EXM: assert (exm_dst != '0 || (ex_sel_a != 2'b01 && ex_sel_b != 2'b01
                                   && id_sel_a == 2'b00 && id_sel_b == 2'b00)); // R5
        AST_BUBBLE_MWB: assert (mwb_wr || (ex_sel_a != 2'b10 && ex_sel_b != 2'b10)); // R6
        AST_BUBBLE_EXM: assert (exm_wr || (ex_sel_a != 2'b01 && id_sel_a == 2'b00)); // R6
        AST_LOAD_NO_BYPASS: assert (!exm_ld || (ex_sel_a != 2'b01 && id_sel_b != 2'b01)); // R7
        AST_EXM_PRIORITY: assert (!(exm_wr && !exm_ld && exm_dst != '0 && exm_dst == ex_src_a)
                                  || ex_sel_a == 2'b01); // R4
        AST_ID_NEEDS_EXM: assert (id_sel_a != 2'b01 || (exm_wr && exm_dst == id_src_a)); // R8
    end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W)) u_chk (
    .id_src_a(id_src_a), .id_src_b(id_src_b),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .exm_dst(exm_dst), .exm_wr(exm_wr), .exm_ld(exm_ld),
    .mwb_dst(mwb_dst), .mwb_wr(mwb_wr),
    .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
    .id_sel_a(id_sel_a), .id_sel_b(id_sel_b)
);

// File: tb/sim_fwd_unit.sv
// Exhaustive sweep of fwd_unit with 3-bit register numbers.
module sim_fwd_unit;
    localparam int CLK_P = 10;
    localparam int RW    = 3;
    localparam int NR    = 1 << RW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] id_src_a = '0, id_src_b = '0, ex_src_a = '0, ex_src_b = '0;
    logic [RW-1:0] exm_dst = '0, mwb_dst = '0;
    logic          exm_wr = 1'b0, exm_ld = 1'b0, mwb_wr = 1'b0;
    logic [1:0]    ex_sel_a, ex_sel_b, id_sel_a, id_sel_b;
    int            n_run = 0, n_fail = 0;
    bit            done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fwd_unit #(.REG_W(RW)) u0 (
        .id_src_a(id_src_a), .id_src_b(id_src_b),
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .exm_dst(exm_dst), .exm_wr(exm_wr), .exm_ld(exm_ld),
        .mwb_dst(mwb_dst), .mwb_wr(mwb_wr),
        .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
        .id_sel_a(id_sel_a), .id_sel_b(id_sel_b));

    // Expected execute select from the requirements.
    function automatic logic [1:0] exp_ex(input logic [RW-1:0] s);
        bit e = exm_wr && exm_dst != 0 && exm_dst == s;
        bit m = mwb_wr && mwb_dst != 0 && mwb_dst == s;
        if (e) return exm_ld ? 2'b00 : 2'b01;
        if (m) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [1:0] exp_id(input logic [RW-1:0] s);
        return (exm_wr && !exm_ld && exm_dst != 0 && exm_dst == s) ? 2'b01 : 2'b00;
    endfunction

    // Requirement that governs the given execute operand case.
    function automatic string tag_ex(input logic [RW-1:0] s);
        bit e = exm_wr && exm_dst != 0 && exm_dst == s;
        bit m = mwb_wr && mwb_dst != 0 && mwb_dst == s;
        if (s == 0 && ((exm_wr && exm_dst == 0) || (mwb_wr && mwb_dst == 0))) return "R5";
        if (e && exm_ld) return "R7";
        if (e && m) return "R4";
        if (e) return "R2";
        if (m) return "R3";
        if ((!exm_wr && exm_dst == s) || (!mwb_wr && mwb_dst == s)) return "R6";
        return "R1";
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (exm %0d/%b/%b mwb %0d/%b)",
                     tag, act, exp, exm_dst, exm_wr, exm_ld, mwb_dst, mwb_wr);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", ex_sel_a, 2'b00);
        check("R8 reset", id_sel_a, 2'b00);
        for (int s = 0; s < NR; s++) begin
            for (int d1 = 0; d1 < NR; d1++) begin
                for (int d2 = 0; d2 < NR; d2++) begin
                    for (int f = 0; f < 8; f++) begin
                        @(posedge clk);
                        ex_src_a = RW'(s);
                        ex_src_b = RW'(s + 3);
                        id_src_a = RW'(s);
                        id_src_b = RW'(s + 5);
                        exm_dst  = RW'(d1);
                        mwb_dst  = RW'(d2);
                        exm_wr   = f[0];
                        exm_ld   = f[1];
                        mwb_wr   = f[2];
                        @(negedge clk);
                        check(tag_ex(ex_src_a), ex_sel_a, exp_ex(ex_src_a));
                        check({"R10 ", tag_ex(ex_src_b)}, ex_sel_b, exp_ex(ex_src_b));
                        check(exm_ld ? "R7 id" : "R8", id_sel_a, exp_id(id_src_a));
                        check("R10 R8", id_sel_b, exp_id(id_src_b));
                        check("R9", {1'b0, (ex_sel_a == 2'b11) | (id_sel_b[1])}, 2'b00);
                    end
                end
            end
        end
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_P * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule